// File: doc/BRIEF.md
# Multiplexed-Address DRAM with Row Buffer

This block is a synchronous model of a bit-organized dynamic memory array together with its access control. The cell address is divided into a row half and a column half of equal width. Both halves travel over one shared set of address pins in two separate cycles. An active-low row strobe qualifies the row half, and an active-low column strobe qualifies the column half. Every location stores one bit, so the data path is a single input line and a single output line.

Opening a row copies the whole selected row into a static row buffer. While the row stays open, any number of column strobes read or write single bits of that buffer without touching the array. When the row strobe returns high, the buffer, with any column writes merged in, is written back to its row. A column strobe that arrives while no row is open is dropped and reported on an error output.

`ADDR_BITS` sets the width of each address half. The full-size part uses 11, which gives 2048 rows of 2048 bits. The default is smaller so the model stays light in simulation, and the row/column split is kept at any size.

Top module: `mux_addr_dram`

## Requirements
- R1: After reset, `dOut`, `dValid` and `accessErr` are 0, and every cell of the array reads as 0.
- R2: The first clock edge at which `rasN` is sampled low, after being sampled high, opens the row whose number is on `addrIn`. Later column strobes then address bit `addrIn` of that row.
- R3: A column read is a `casN` falling sample with `weN`=1 while a row is open. After that edge, `dOut` holds bit `addrIn` of the open row's buffer and `dValid` is 1. `dValid` stays high for that one cycle only.
- R4: A column write is a `casN` falling sample with `weN`=0 while a row is open. It stores `dIn` into bit `addrIn` of the buffer, and later reads of the same open row return the written value. Other columns are not changed.
- R5: When `rasN` is sampled high after being low, the buffer is written back to the open row and the row closes. The written data are still there when the row is opened again, and other rows are not changed.
- R6: Only a high-to-low transition of `casN` starts an access. Holding `casN` low for several cycles gives exactly one access, with `dValid` high for one cycle.
- R7: A `casN` falling sample while no row is open changes no cell and gives no `dValid`. Instead, `accessErr` is 1 for exactly one cycle after that edge.
- R8: A column write sampled at the same edge that closes the row is included in that row's write-back.
- R9: A `casN` falling sample at the same edge as the `rasN` falling sample counts as an access with no open row (R7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_BITS | Shared row/column address pins |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable, sampled with the column strobe |
| dIn | input | 1 | Write data bit |
| dOut | output | 1 | Read data bit, held until the next read |
| dValid | output | 1 | One-cycle pulse marking new read data on `dOut` |
| accessErr | output | 1 | One-cycle pulse for a column strobe without an open row |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a column write and the write-back of the closing row. The bench provokes it by lowering `casN` and raising `rasN` at the same edge. It judges the result by reopening that row and reading the column back: the written bit must be there.

The second pair is a row activation and a column strobe at the same edge. The bench judges this case by the one-cycle `accessErr` pulse with no `dValid`.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

  // Strobes sent from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic loadRow;    // copy the addressed row into the buffer
    logic writeBack;  // store the (merged) buffer into the open row
    logic colWrite;   // write dIn into the addressed buffer bit
    logic colRead;    // drive the addressed buffer bit to dOut
  } dramCtl_t;

endpackage

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mux_dram_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rasN,
  input  logic     casN,
  input  logic     weN,
  output dramCtl_t ctl,
  output logic     rowOpen,
  output logic     accessErr
);

  logic prevRas;
  logic prevCas;
  logic rasFall;
  logic rasRise;
  logic casFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRas <= 1'b1;
      prevCas <= 1'b1;
    end else begin
      prevRas <= rasN;
      prevCas <= casN;
    end
  end

  always_comb begin
    rasFall       = !rasN && prevRas;
    rasRise       = rasN && !prevRas;
    casFall       = !casN && prevCas;
    ctl.loadRow   = rasFall;
    ctl.writeBack = rasRise && rowOpen;
    ctl.colWrite  = casFall && rowOpen && !weN;
    ctl.colRead   = casFall && rowOpen && weN;
  end

  // A row opened at this edge is not yet usable by a column strobe at the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen   <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      if (rasFall) begin
        rowOpen <= 1'b1;
      end else if (rasRise) begin
        rowOpen <= 1'b0;
      end
      accessErr <= casFall && !rowOpen;
    end
  end

endmodule

// File: rtl/mux_dram_datapath.sv
module mux_dram_datapath
  import mux_dram_pkg::*;
#(
  parameter int ADDR_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dramCtl_t             ctl,
  input  logic [ADDR_BITS-1:0] addrIn,
  input  logic                 dIn,
  output logic                 dOut,
  output logic                 dValid
);

  localparam int NUM_ROWS  = 1 << ADDR_BITS;
  localparam int ROW_WIDTH = 1 << ADDR_BITS;

  logic [ROW_WIDTH-1:0] cellArray [NUM_ROWS];
  logic [ROW_WIDTH-1:0] rowBuf;
  logic [ROW_WIDTH-1:0] mergedBuf;
  logic [ADDR_BITS-1:0] openRowAddr;

  // Buffer with the current column write applied, so a write and a
  // write-back at the same edge both take effect.
  always_comb begin
    mergedBuf = rowBuf;
    if (ctl.colWrite) begin
      mergedBuf[addrIn] = dIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        cellArray[r] <= '0;
      end
    end else if (ctl.writeBack) begin
      cellArray[openRowAddr] <= mergedBuf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBuf      <= '0;
      openRowAddr <= '0;
    end else if (ctl.loadRow) begin
      rowBuf      <= cellArray[addrIn];
      openRowAddr <= addrIn;
    end else if (ctl.colWrite) begin
      rowBuf <= mergedBuf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOut   <= 1'b0;
      dValid <= 1'b0;
    end else begin
      dValid <= ctl.colRead;
      if (ctl.colRead) begin
        dOut <= rowBuf[addrIn];
      end
    end
  end

endmodule

// File: rtl/mux_addr_dram.sv
module mux_addr_dram
  import mux_dram_pkg::*;
#(
  parameter int ADDR_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_BITS-1:0] addrIn,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 dIn,
  output logic                 dOut,
  output logic                 dValid,
  output logic                 accessErr
);

  dramCtl_t ctl;
  logic     rowOpen;

  mux_dram_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .ctl       (ctl),
    .rowOpen   (rowOpen),
    .accessErr (accessErr)
  );

  mux_dram_datapath #(.ADDR_BITS(ADDR_BITS)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .addrIn (addrIn),
    .dIn    (dIn),
    .dOut   (dOut),
    .dValid (dValid)
  );

endmodule

// File: rtl/mux_dram_checker.sv
module mux_dram_checker (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic rowOpen,
  input logic dValid,
  input logic accessErr
);

  // R2: a row strobe fall opens a row
  p_open_on_ras_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |=> rowOpen);

  // R3: a read strobe on an open row yields valid data next cycle
  p_read_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && rowOpen && weN) |=> dValid);

  // R5: a row strobe rise closes the row
  p_close_on_ras_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |=> !rowOpen);

  // R6: valid data never lasts two cycles
  p_single_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    dValid |=> !dValid);

  // R7: strobe with no open row flags an error and gives no data
  p_err_no_row_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !rowOpen) |=> (accessErr && !dValid));

  // R7: an error and valid data never coincide
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(accessErr && dValid));

endmodule

bind mux_addr_dram mux_dram_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rasN      (rasN),
  .casN      (casN),
  .weN       (weN),
  .rowOpen   (rowOpen),
  .dValid    (dValid),
  .accessErr (accessErr)
);

// File: tb/test_mux_addr_dram.sv
module test_mux_addr_dram;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_BITS  = 5;
  localparam int LAST_COL   = (1 << ADDR_BITS) - 1;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [ADDR_BITS-1:0] addrIn = '0;
  logic                 rasN = 1'b1;
  logic                 casN = 1'b1;
  logic                 weN = 1'b1;
  logic                 dIn = 1'b0;
  logic                 dOut;
  logic                 dValid;
  logic                 accessErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_addr_dram #(.ADDR_BITS(ADDR_BITS)) i_mux_addr_dram (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .dIn       (dIn),
    .dOut      (dOut),
    .dValid    (dValid),
    .accessErr (accessErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic openRow(input int r);
    @(negedge clk);
    addrIn = ADDR_BITS'(r);
    rasN   = 1'b0;
    @(negedge clk);
  endtask

  task automatic closeRow();
    @(negedge clk);
    rasN = 1'b1;
    @(negedge clk);
  endtask

  task automatic colRead(input int c, input int exp, input string tag);
    @(negedge clk);
    addrIn = ADDR_BITS'(c);
    weN    = 1'b1;
    casN   = 1'b0;
    @(posedge clk); #1;
    check({tag, " dValid"}, int'(dValid), 1);
    check({tag, " dOut"}, int'(dOut), exp);
    @(negedge clk);
    casN = 1'b1;
    @(posedge clk); #1;
    check({tag, " dValid drop R3"}, int'(dValid), 0);
  endtask

  task automatic colWrite(input int c, input logic b);
    @(negedge clk);
    addrIn = ADDR_BITS'(c);
    weN    = 1'b0;
    dIn    = b;
    casN   = 1'b0;
    @(negedge clk);
    casN = 1'b1;
    weN  = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 dOut", int'(dOut), 0);
    check("R1 dValid", int'(dValid), 0);
    check("R1 accessErr", int'(accessErr), 0);
    openRow(3);
    colRead(5, 0, "R1 cleared cell");
    colRead(LAST_COL, 0, "R1 cleared last cell");
    closeRow();
  endtask

  task automatic t_writeBack();
    openRow(3);
    colWrite(5, 1'b1);
    colWrite(0, 1'b1);
    colWrite(LAST_COL, 1'b1);
    colRead(5, 1, "R4 written col5");
    colRead(6, 0, "R4 neighbour col6");
    colRead(1, 0, "R4 neighbour col1");
    closeRow();
    openRow(4);
    colRead(5, 0, "R5 other row");
    closeRow();
    openRow(3);
    colRead(5, 1, "R5 reopened col5");
    colRead(LAST_COL, 1, "R5 reopened last col");
    colRead(0, 1, "R2 reopened col0");
    closeRow();
  endtask

  task automatic t_holdCas();
    openRow(3);
    @(negedge clk);
    addrIn = ADDR_BITS'(5);
    weN    = 1'b1;
    casN   = 1'b0;
    @(posedge clk); #1;
    check("R6 first dValid", int'(dValid), 1);
    check("R6 dOut", int'(dOut), 1);
    @(posedge clk); #1;
    check("R6 held strobe no new access", int'(dValid), 0);
    @(posedge clk); #1;
    check("R6 held strobe still quiet", int'(dValid), 0);
    @(negedge clk);
    casN = 1'b1;
    closeRow();
  endtask

  task automatic t_noRow();
    @(negedge clk);
    addrIn = ADDR_BITS'(7);
    weN    = 1'b0;
    dIn    = 1'b1;
    casN   = 1'b0;
    @(posedge clk); #1;
    check("R7 accessErr", int'(accessErr), 1);
    check("R7 no dValid", int'(dValid), 0);
    @(posedge clk); #1;
    check("R7 accessErr one cycle", int'(accessErr), 0);
    @(negedge clk);
    casN = 1'b1;
    weN  = 1'b1;
    openRow(3);
    colRead(7, 0, "R7 last row untouched");
    closeRow();
    openRow(7);
    colRead(7, 0, "R7 addressed row untouched");
    closeRow();
  endtask

  task automatic t_sameEdgeOpen();
    @(negedge clk);
    addrIn = ADDR_BITS'(9);
    weN    = 1'b1;
    rasN   = 1'b0;
    casN   = 1'b0;
    @(posedge clk); #1;
    check("R9 accessErr", int'(accessErr), 1);
    check("R9 no dValid", int'(dValid), 0);
    @(negedge clk);
    casN = 1'b1;
    colRead(2, 0, "R9 row usable afterwards");
    closeRow();
  endtask

  task automatic t_writeAtClose();
    openRow(10);
    @(negedge clk);
    addrIn = ADDR_BITS'(2);
    weN    = 1'b0;
    dIn    = 1'b1;
    casN   = 1'b0;
    rasN   = 1'b1;
    @(posedge clk); #1;
    check("R8 no error at close", int'(accessErr), 0);
    @(negedge clk);
    casN = 1'b1;
    weN  = 1'b1;
    openRow(10);
    colRead(2, 1, "R8 merged write-back");
    colRead(3, 0, "R8 neighbour");
    closeRow();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_writeBack();
    t_holdCas();
    t_noRow();
    t_sameEdgeOpen();
    t_writeAtClose();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule